// File: doc/BRIEF.md
# Two-level interrupt status controller

This block gathers the interrupt sources of a storage-card host interface into one sticky status register with a matching enable register. The enabled and pending sources merge into one "card" bit of a global status register. A second peripheral's interrupt request fills the other global bit. Each global bit is captured only when its capture-enable bit is set. The single interrupt line is driven by the global status bits whose signal-enable bit is set. Software reads the global status to see which peripheral raised the line, then reads the source status. It clears what it saw by writing ones back to each register.

Card insertion is tracked from two active-low card-detect pins. Both pins pass through a two-stage synchroniser. A small state machine with the states `CARD_ABSENT` and `CARD_PRESENT` follows the combined condition "both pins low". The transition *insert* (`CARD_ABSENT` to `CARD_PRESENT`) and the transition *remove* (`CARD_PRESENT` to `CARD_ABSENT`) each raise a one-cycle card-detect event. The other sources arrive as one-cycle pulses from the transfer logic: transfer error, buffer available, transfer done, and four mode/status-change events.

Registers are word-addressed on a simple bus. Writes take effect on the clock edge that samples `reg_wr`. Reads are combinational from `reg_addr`.

Top module: `irqc_top`

## Requirements
- R1: After reset the source status, source enable, global status, capture-enable and signal-enable registers read 0, `irq` is low, and the interface-status register (address 0) reads 0x0C.
- R2: A source pulse sets its bit in the source status register (address 1) at the clock edge that samples it, whatever the enable mask holds. The bit positions are: bit 0 card detect, bits 1/2/3 `evt_mode[0]/[1]/[2]`, bit 8 `evt_mode[3]`, bit 9 transfer error, bit 10 buffer available, bit 11 transfer done.
- R3: Writing the source status register clears exactly the bits written as 1 and leaves the others unchanged.
- R4: When a set and a write-1 clear reach the same status bit in the same cycle, the bit ends up set. This holds at both levels.
- R5: The interface-status register shows the synchronised `cd1_n` at bit 2 and `cd2_n` at bit 3. The card counts as inserted only when both are low. Each change of that inserted condition sets source bit 0 on the third clock edge after the pin change.
- R6: Global status bit 0 is set one edge after any bit of (source status AND source enable, address 2) is 1 while capture-enable (address 4) bit 0 is 1. Global bit 1 is set one edge after `nb_irq` is high while capture-enable bit 1 is 1.
- R7: Writing 1 to a bit of the global status register (address 3) clears it, provided no capture is pending for that bit.
- R8: `irq` is high exactly when some global status bit is 1 and the same bit of signal-enable (address 5) is 1.
- R9: A source whose enable bit is 0, or a global input whose capture-enable bit is 0, leaves the global status unchanged.
- R10: The unused source status and enable bits (4 to 7 and 12 up), unused global bits, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW (4) | Word address of register access |
| reg_wdata | input | DW (32) | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | DW (32) | Read data for `reg_addr` |
| cd1_n | input | 1 | Card-detect pin 1, active low, asynchronous |
| cd2_n | input | 1 | Card-detect pin 2, active low, asynchronous |
| evt_xfer_err | input | 1 | Transfer-error pulse |
| evt_buf_avail | input | 1 | Buffer-available pulse |
| evt_xfer_done | input | 1 | Transfer-done pulse |
| evt_mode | input | 4 | Status-change and mode event pulses |
| nb_irq | input | 1 | Neighbouring peripheral's interrupt level |
| irq | output | 1 | Shared interrupt line, level |

## Verification
The assertions assume several things about the inputs:
- Register writes and source pulses are synchronous to `clk`.
- Only the synchronised copy of the card-detect pins reaches any checked logic.
- Reset is asserted before the first edge that counts.

The stimulus meets these assumptions by driving every input, the pins included, at the falling edge and by sampling half a cycle later. The card-detect checks count the three edges between a pin change and the status bit. The same-cycle set/clear cases are driven deliberately in one falling-edge slot.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_W     = 12;
    localparam int G_W       = 2;
    localparam int SB_CARD   = 0;
    localparam int SB_STCHG  = 1;
    localparam int SB_MEMM   = 2;
    localparam int SB_IOM    = 3;
    localparam int SB_IDEM   = 8;
    localparam int SB_XERR   = 9;
    localparam int SB_BUF    = 10;
    localparam int SB_DONE   = 11;
    localparam logic [SRC_W-1:0] SRC_VALID = 12'hF0F;
    localparam int GB_CF     = 0;
    localparam int GB_NB     = 1;
    localparam int A_IFSTAT  = 0;
    localparam int A_SSTAT   = 1;
    localparam int A_SEN     = 2;
    localparam int A_GSTAT   = 3;
    localparam int A_GCAP    = 4;
    localparam int A_GSIG    = 5;

    typedef enum logic {
        CARD_ABSENT  = 1'b0,
        CARD_PRESENT = 1'b1
    } card_st_e;
endpackage

// File: rtl/irqc_card_track.sv
module irqc_card_track
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cd1_n,
    input  logic       cd2_n,
    output logic [1:0] cd_sync,
    output logic       cd_evt
);
    logic [1:0] sync_q [SYNC_STAGES];
    card_st_e   state, state_nxt;
    logic       inserted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 2'b11;
        else        sync_q[0] <= {cd2_n, cd1_n};
    end

    generate
        for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 2'b11;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    assign cd_sync  = sync_q[SYNC_STAGES-1];
    assign inserted = (cd_sync == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CARD_ABSENT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        cd_evt    = 1'b0;
        unique case (state)
            CARD_ABSENT: if (inserted) begin
                state_nxt = CARD_PRESENT;
                cd_evt    = 1'b1;
            end
            CARD_PRESENT: if (!inserted) begin
                state_nxt = CARD_ABSENT;
                cd_evt    = 1'b1;
            end
        endcase
    end

    AST_CD_EVT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        cd_evt |=> (state != $past(state))); // R5
    AST_CD_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cd_evt |=> $stable(state)); // R5
endmodule

// File: rtl/irqc_src_level.sv
module irqc_src_level #(
    parameter int W = 12,
    parameter logic [W-1:0] VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         wr_stat,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] stat,
    output logic [W-1:0] en,
    output logic         pend
);
    logic [W-1:0] clr_vec;

    assign clr_vec = wr_stat ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= ((stat & ~clr_vec) | set_vec) & VALID;
            if (wr_en) en <= wdata & VALID;
        end
    end

    assign pend = |(stat & en);

    AST_SRC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_vec & VALID)) |=> ((stat & $past(set_vec & VALID)) == $past(set_vec & VALID))); // R2 R4
    AST_SRC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && |(wdata & ~set_vec)) |=> ((stat & $past(wdata & ~set_vec)) == '0)); // R3
endmodule

// File: rtl/irqc_glob_level.sv
module irqc_glob_level
    import irqc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cf_pend,
    input  logic           nb_irq,
    input  logic           wr_stat,
    input  logic           wr_cap,
    input  logic           wr_sig,
    input  logic [G_W-1:0] wdata,
    output logic [G_W-1:0] gstat,
    output logic [G_W-1:0] cap_en,
    output logic [G_W-1:0] sig_en,
    output logic           irq
);
    logic [G_W-1:0] raw, set_vec, clr_vec;

    always_comb begin
        raw        = '0;
        raw[GB_CF] = cf_pend;
        raw[GB_NB] = nb_irq;
    end

    assign set_vec = raw & cap_en;
    assign clr_vec = wr_stat ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gstat  <= '0;
            cap_en <= '0;
            sig_en <= '0;
        end else begin
            gstat <= (gstat & ~clr_vec) | set_vec;
            if (wr_cap) cap_en <= wdata;
            if (wr_sig) sig_en <= wdata;
        end
    end

    assign irq = |(gstat & sig_en);

    AST_GCAP_CF: assert property (@(posedge clk) disable iff (!rst_n)
        (cf_pend && cap_en[GB_CF]) |=> gstat[GB_CF]); // R6
    AST_GGATE_CF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gstat[GB_CF]) |-> $past(cf_pend && cap_en[GB_CF])); // R9
    AST_GCLR_CF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[GB_CF] && !(cf_pend && cap_en[GB_CF])) |=> !gstat[GB_CF]); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en == '0) |-> !irq); // R8
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int AW          = 4,
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_wr,
    output logic [DW-1:0] reg_rdata,
    input  logic          cd1_n,
    input  logic          cd2_n,
    input  logic          evt_xfer_err,
    input  logic          evt_buf_avail,
    input  logic          evt_xfer_done,
    input  logic [3:0]    evt_mode,
    input  logic          nb_irq,
    output logic          irq
);
    localparam logic [AW-1:0] ADR_IFSTAT = AW'(A_IFSTAT);
    localparam logic [AW-1:0] ADR_SSTAT  = AW'(A_SSTAT);
    localparam logic [AW-1:0] ADR_SEN    = AW'(A_SEN);
    localparam logic [AW-1:0] ADR_GSTAT  = AW'(A_GSTAT);
    localparam logic [AW-1:0] ADR_GCAP   = AW'(A_GCAP);
    localparam logic [AW-1:0] ADR_GSIG   = AW'(A_GSIG);

    logic [1:0]       cd_sync;
    logic             cd_evt;
    logic [SRC_W-1:0] src_set, src_stat, src_en;
    logic             cf_pend;
    logic [G_W-1:0]   gstat, gcap, gsig;

    irqc_card_track #(.SYNC_STAGES(SYNC_STAGES)) u_card (
        .clk     (clk),
        .rst_n   (rst_n),
        .cd1_n   (cd1_n),
        .cd2_n   (cd2_n),
        .cd_sync (cd_sync),
        .cd_evt  (cd_evt)
    );

    always_comb begin
        src_set           = '0;
        src_set[SB_CARD]  = cd_evt;
        src_set[SB_STCHG] = evt_mode[0];
        src_set[SB_MEMM]  = evt_mode[1];
        src_set[SB_IOM]   = evt_mode[2];
        src_set[SB_IDEM]  = evt_mode[3];
        src_set[SB_XERR]  = evt_xfer_err;
        src_set[SB_BUF]   = evt_buf_avail;
        src_set[SB_DONE]  = evt_xfer_done;
    end

    irqc_src_level #(.W(SRC_W), .VALID(SRC_VALID)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (src_set),
        .wr_stat (reg_wr && reg_addr == ADR_SSTAT),
        .wr_en   (reg_wr && reg_addr == ADR_SEN),
        .wdata   (reg_wdata[SRC_W-1:0]),
        .stat    (src_stat),
        .en      (src_en),
        .pend    (cf_pend)
    );

    irqc_glob_level u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .cf_pend (cf_pend),
        .nb_irq  (nb_irq),
        .wr_stat (reg_wr && reg_addr == ADR_GSTAT),
        .wr_cap  (reg_wr && reg_addr == ADR_GCAP),
        .wr_sig  (reg_wr && reg_addr == ADR_GSIG),
        .wdata   (reg_wdata[G_W-1:0]),
        .gstat   (gstat),
        .cap_en  (gcap),
        .sig_en  (gsig),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_IFSTAT: reg_rdata[3:2]       = cd_sync;
            ADR_SSTAT:  reg_rdata[SRC_W-1:0] = src_stat;
            ADR_SEN:    reg_rdata[SRC_W-1:0] = src_en;
            ADR_GSTAT:  reg_rdata[G_W-1:0]   = gstat;
            ADR_GCAP:   reg_rdata[G_W-1:0]   = gcap;
            ADR_GSIG:   reg_rdata[G_W-1:0]   = gsig;
            default:    reg_rdata            = '0;
        endcase
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > ADR_GSIG) |-> (reg_rdata == '0)); // R10
endmodule

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic        cd1_n = 1'b1, cd2_n = 1'b1;
    logic        evt_xfer_err = 1'b0, evt_buf_avail = 1'b0, evt_xfer_done = 1'b0;
    logic [3:0]  evt_mode = '0;
    logic        nb_irq = 1'b0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .cd1_n(cd1_n), .cd2_n(cd2_n),
        .evt_xfer_err(evt_xfer_err), .evt_buf_avail(evt_buf_avail),
        .evt_xfer_done(evt_xfer_done), .evt_mode(evt_mode), .nb_irq(nb_irq), .irq(irq)
    );

    localparam logic [2:0] OP_W = 0, OP_R = 1, OP_P = 2, OP_N = 3, OP_Q = 4, OP_I = 5;

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  adr;
        logic [31:0] dat;
        logic [31:0] exp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t TBL [NV] = '{
        '{OP_W, 4'd2, 32'h0000_0400, 32'h0,   8'd6 },  // enable buffer-available only
        '{OP_W, 4'd4, 32'h0000_0003, 32'h0,   8'd6 },
        '{OP_W, 4'd5, 32'h0000_0001, 32'h0,   8'd8 },
        '{OP_R, 4'd2, 32'h0,         32'h400, 8'd10},  // R10 enable readback
        '{OP_P, 4'd0, 32'h0000_0200, 32'h0,   8'd2 },  // transfer error, disabled
        '{OP_R, 4'd1, 32'h0,         32'h200, 8'd2 },  // R2 sets regardless of enable
        '{OP_I, 4'd0, 32'h0,         32'h0,   8'd9 },
        '{OP_R, 4'd3, 32'h0,         32'h0,   8'd9 },  // R9 no global capture
        '{OP_Q, 4'd0, 32'h0,         32'h0,   8'd9 },
        '{OP_P, 4'd0, 32'h0000_0400, 32'h0,   8'd2 },
        '{OP_R, 4'd1, 32'h0,         32'h600, 8'd2 },
        '{OP_R, 4'd3, 32'h0,         32'h1,   8'd6 },  // R6 card bit captured
        '{OP_Q, 4'd0, 32'h0,         32'h1,   8'd8 },  // R8 line up
        '{OP_W, 4'd1, 32'h0000_0600, 32'h0,   8'd3 },
        '{OP_R, 4'd1, 32'h0,         32'h0,   8'd3 },  // R3 write-back clears
        '{OP_R, 4'd3, 32'h0,         32'h1,   8'd7 },  // R7 global sticky
        '{OP_W, 4'd3, 32'h0000_0001, 32'h0,   8'd7 },
        '{OP_R, 4'd3, 32'h0,         32'h0,   8'd7 },  // R7 cleared
        '{OP_Q, 4'd0, 32'h0,         32'h0,   8'd8 },
        '{OP_P, 4'd0, 32'h0000_010E, 32'h0,   8'd2 },  // mode events
        '{OP_R, 4'd1, 32'h0,         32'h10E, 8'd2 },
        '{OP_W, 4'd1, 32'h0000_0002, 32'h0,   8'd3 },
        '{OP_R, 4'd1, 32'h0,         32'h10C, 8'd3 },  // R3 partial clear
        '{OP_W, 4'd1, 32'hFFFF_FFFF, 32'h0,   8'd3 },
        '{OP_R, 4'd1, 32'h0,         32'h0,   8'd3 },
        '{OP_N, 4'd0, 32'h1,         32'h0,   8'd6 },
        '{OP_R, 4'd3, 32'h0,         32'h2,   8'd6 },  // R6 neighbour bit
        '{OP_Q, 4'd0, 32'h0,         32'h0,   8'd8 },  // R8 not signal-enabled
        '{OP_W, 4'd5, 32'h0000_0003, 32'h0,   8'd8 },
        '{OP_Q, 4'd0, 32'h0,         32'h1,   8'd8 },
        '{OP_N, 4'd0, 32'h0,         32'h0,   8'd7 },
        '{OP_W, 4'd3, 32'h0000_0002, 32'h0,   8'd7 },
        '{OP_R, 4'd3, 32'h0,         32'h0,   8'd7 },
        '{OP_Q, 4'd0, 32'h0,         32'h0,   8'd8 },
        '{OP_W, 4'd2, 32'hFFFF_FFFF, 32'h0,   8'd10},
        '{OP_R, 4'd2, 32'h0,         32'hF0F, 8'd10}   // R10 unused enable bits
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int rq);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] m, input logic [31:0] e, input int rq);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata & m, e, rq);
    endtask

    task automatic drive_evt(input logic [11:0] v);
        evt_mode      = {v[8], v[3], v[2], v[1]};
        evt_xfer_err  = v[9];
        evt_buf_avail = v[10];
        evt_xfer_done = v[11];
    endtask

    task automatic pulse(input logic [11:0] v);
        @(negedge clk);
        drive_evt(v);
        @(negedge clk);
        drive_evt('0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd0, 32'hFFFF_FFFF, 32'h0C, 1);
        for (int a = 1; a <= 5; a++) rd(4'(a), 32'hFFFF_FFFF, 32'h0, 1);
        #1 chk({31'b0, irq}, 32'h0, 1);
        // R10 unmapped address
        rd(4'd7, 32'hFFFF_FFFF, 32'h0, 10);

        for (int i = 0; i < NV; i++) begin
            unique case (TBL[i].op)
                OP_W: wr(TBL[i].adr, TBL[i].dat);
                OP_R: rd(TBL[i].adr, 32'hFFFF_FFFF, TBL[i].exp, int'(TBL[i].rq));
                OP_P: pulse(TBL[i].dat[11:0]);
                OP_N: begin @(negedge clk); nb_irq = TBL[i].dat[0]; end
                OP_Q: begin @(negedge clk); #1 chk({31'b0, irq}, TBL[i].exp, int'(TBL[i].rq)); end
                default: @(negedge clk);
            endcase
        end

        // R4 set wins over same-cycle clear, source level
        pulse(12'h400);
        @(negedge clk);
        reg_addr = 4'd1; reg_wdata = 32'h400; reg_wr = 1'b1; evt_buf_avail = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; evt_buf_avail = 1'b0;
        rd(4'd1, 32'hFFFF_FFFF, 32'h400, 4);
        wr(4'd1, 32'h400);
        rd(4'd1, 32'hFFFF_FFFF, 32'h0, 3);
        // R4 global level: neighbour high while clearing its bit
        wr(4'd2, 32'h0);
        wr(4'd3, 32'h3);
        @(negedge clk); nb_irq = 1'b1;
        wr(4'd3, 32'h2);
        rd(4'd3, 32'hFFFF_FFFF, 32'h2, 4);
        @(negedge clk); nb_irq = 1'b0;
        wr(4'd3, 32'h2);
        rd(4'd3, 32'hFFFF_FFFF, 32'h0, 7);

        // R5 one pin low is not an insertion
        @(negedge clk); cd1_n = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'd0, 32'hFFFF_FFFF, 32'h08, 5);
        rd(4'd1, 32'h1, 32'h0, 5);
        // R5 both low: event on third edge
        @(negedge clk); cd2_n = 1'b0;
        @(negedge clk);
        rd(4'd1, 32'h1, 32'h0, 5);
        rd(4'd1, 32'h1, 32'h1, 5);
        rd(4'd0, 32'hFFFF_FFFF, 32'h00, 5);
        wr(4'd1, 32'h1);
        repeat (4) @(negedge clk);
        rd(4'd1, 32'h1, 32'h0, 5);
        // R5 removal raises the event again
        @(negedge clk); cd2_n = 1'b1;
        @(negedge clk);
        rd(4'd1, 32'h1, 32'h0, 5);
        rd(4'd1, 32'h1, 32'h1, 5);
        rd(4'd0, 32'hFFFF_FFFF, 32'h08, 5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule